// File: doc/BRIEF.md
# Multi-format audio serial port

This block moves stereo audio samples between a parallel word interface and a three-wire serial link made of a bit clock, a frame clock and one data line in each direction. A frame carries 64 bit periods, split into two 32-slot halves. The half with the frame clock low holds the left channel, and the half with it high holds the right channel. Each sample sits in its half according to the selected framing: MSB-justified (first slot onward), LSB-justified (ending on the last slot) or I2S-compatible (MSB one slot after the frame clock edge). Slots outside the sample carry zero.

As clock master, the block divides its system clock to make the bit clock and the frame clock. As clock slave, it forwards the external clocks to its clock outputs and frames its data from them after synchronising them into the system clock domain. Transmit words are written with a strobe and take effect at the start of the next frame. A received pair is delivered with a single-cycle valid pulse once the right channel's last data bit is in. Word lengths of 16, 20, 24 and 32 bits are supported. The 32-bit length is meant for the two justified framings.

Top module: `audio_serial_port`

## Requirements
- R1: While `rst_n` is low, with `master` high, `sdOut`, `bitClkOut`, `frameClkOut` and `rxValid` are all low.
- R2: In master mode each bit clock phase lasts `DIV_HALF` system clocks, giving a 50% duty cycle, and one frame clock period contains exactly 64 bit clock rising edges.
- R3: The frame clock is low for the 32 left-channel slots and high for the 32 right-channel slots, and it changes only at a half-frame boundary.
- R4: `sdOut` changes only after a bit clock falling edge. `sdIn` is taken at the bit clock rising edge.
- R5: With `fmt` = 0 (MSB-justified; code 3 behaves the same), the sample's MSB occupies slot 0 and the following bits fill successive slots. `wordSel` = 0/1/2/3 selects 16/20/24/32 bits.
- R6: With `fmt` = 1 (LSB-justified), the sample's LSB occupies slot 31 for word lengths 16, 20 and 24.
- R7: With `fmt` = 2 (I2S-compatible), the sample's MSB occupies slot 1, one bit clock after the frame clock edge.
- R8: Every slot of a half-frame that carries no sample bit is transmitted as zero.
- R9: A received pair appears on `rxLeft`/`rxRight`, right-justified and zero-extended, with `rxValid` high for exactly one system clock, once per frame.
- R10: Words written with `txValid` are sent from the next frame start (left slot 0). A frame already in progress keeps both of its old words.
- R11: In slave mode (`master` low), `bitClkOut` and `frameClkOut` equal `bitClkIn` and `frameClkIn`.
- R12: In slave mode, transmit and receive framing follow the external clocks with the same slot layout as in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1: generate clocks, 0: follow external clocks |
| fmt | input | 2 | Framing: 0 MSB-justified, 1 LSB-justified, 2 I2S, 3 as 0 |
| wordSel | input | 2 | Word length: 0 16, 1 20, 2 24, 3 32 bits |
| txLeft | input | 32 | Left transmit word, right-justified |
| txRight | input | 32 | Right transmit word, right-justified |
| txValid | input | 1 | Write strobe for the transmit words |
| rxLeft | output | 32 | Last received left word |
| rxRight | output | 32 | Last received right word |
| rxValid | output | 1 | One-cycle strobe for a new received pair |
| bitClkIn | input | 1 | External bit clock (slave mode) |
| frameClkIn | input | 1 | External frame clock (slave mode) |
| sdIn | input | 1 | Serial receive data |
| bitClkOut | output | 1 | Bit clock output |
| frameClkOut | output | 1 | Frame clock output |
| sdOut | output | 1 | Serial transmit data |

## Verification
The frame-start copy of the held transmit words into the working words and the emission of slot 0 happen in the same system clock. Slot 0 of the left half is therefore sent straight from the held word, not from the working copy. The MSB-justified and 32-bit cases put a data bit in that slot. The load-timing test writes new words in the middle of a left half, then checks that the frame in progress keeps its old words and that the next frame, slot 0 included, carries the new ones.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [1:0] {
    FMT_MSB = 2'd0,
    FMT_LSB = 2'd1,
    FMT_I2S = 2'd2
  } aspFmt_e;

  // one strobe per detected bit clock edge, with the slot it belongs to
  typedef struct packed {
    logic       rise;
    logic       fall;
    logic [5:0] pos;   // [5] = channel (1 right), [4:0] = slot
  } aspStrobe_t;

  function automatic logic [5:0] wordBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int DIV_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master,
  input  logic       bitClkIn,
  input  logic       frameClkIn,
  output logic       bitClkOut,
  output logic       frameClkOut,
  output aspStrobe_t strb
);

  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DIV_W-1:0]       divCnt;
  logic                   genClk;
  logic                   frameReg;
  logic [5:0]             cnt;
  logic [SYNC_STAGES:0]   bPipe;
  logic [SYNC_STAGES-1:0] fPipe;

  logic       divWrap, genRise, genFall, slvRise, slvFall, bS, bPrev, fS;
  logic [5:0] nextCnt, syncPos;

  always_comb begin
    bS      = bPipe[SYNC_STAGES-1];
    bPrev   = bPipe[SYNC_STAGES];
    fS      = fPipe[SYNC_STAGES-1];
    nextCnt = cnt + 6'd1;
    divWrap = (divCnt == DIV_W'(DIV_HALF - 1));
    genRise = master & divWrap & ~genClk;
    genFall = master & divWrap & genClk;
    slvRise = ~master & bS & ~bPrev;
    slvFall = ~master & ~bS & bPrev;
    // realign to the external frame clock when its level disagrees
    syncPos = (fS != cnt[5]) ? {fS, 5'd0} : cnt;
    strb.rise = genRise | slvRise;
    strb.fall = genFall | slvFall;
    if (genFall | slvFall) strb.pos = nextCnt;
    else                   strb.pos = master ? cnt : syncPos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt   <= '0;
      genClk   <= 1'b0;
      frameReg <= 1'b0;
      cnt      <= 6'h3F;
      bPipe    <= '0;
      fPipe    <= '0;
    end else begin
      bPipe <= {bPipe[SYNC_STAGES-1:0], bitClkIn};
      fPipe <= {fPipe[SYNC_STAGES-2:0], frameClkIn};
      if (master) begin
        if (divWrap) begin
          divCnt <= '0;
          genClk <= ~genClk;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
        if (genFall) begin
          cnt      <= nextCnt;
          frameReg <= nextCnt[5];
        end
      end else begin
        divCnt <= '0;
        genClk <= 1'b0;
        if (slvFall)      cnt <= nextCnt;
        else if (slvRise) cnt <= syncPos;
      end
    end
  end

  assign bitClkOut   = master ? genClk   : bitClkIn;
  assign frameClkOut = master ? frameReg : frameClkIn;

  // R3: frame clock moves only when a new half-frame begins
  assert_frame_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && strb.fall && strb.pos[4:0] != 5'd0) |=> $stable(frameClkOut));

endmodule

// File: rtl/asp_dp.sv
module asp_dp
  import asp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wordSel,
  input  aspStrobe_t  strb,
  input  logic [31:0] txLeft,
  input  logic [31:0] txRight,
  input  logic        txValid,
  input  logic        sdIn,
  output logic        sdOut,
  output logic [31:0] rxLeft,
  output logic [31:0] rxRight,
  output logic        rxValid
);

  logic [31:0] holdL, holdR, workL, workR, rxSh, leftHold, rxNext, txWord;
  logic [SYNC_STAGES-1:0] sdPipe;
  logic        leftSeen, ch, inWin, firstBit, lastBit, din, txBit;
  logic [5:0]  wLen, start, slot, rel;
  logic [4:0]  bitIdx;

  always_comb begin
    wLen = wordBits(wordSel);
    case (aspFmt_e'(fmt))
      FMT_LSB: start = 6'd32 - wLen;
      FMT_I2S: start = 6'd1;
      default: start = 6'd0;
    endcase
    slot     = {1'b0, strb.pos[4:0]};
    ch       = strb.pos[5];
    rel      = slot - start;
    inWin    = (slot >= start) && (rel < wLen);
    bitIdx   = 5'(wLen - 6'd1 - rel);
    firstBit = inWin && (rel == 6'd0);
    lastBit  = inWin && (rel == wLen - 6'd1);
    // slot 0 of the left half is sent while the working copy is loaded
    if (ch)             txWord = workR;
    else if (slot == 0) txWord = holdL;
    else                txWord = workL;
    txBit  = inWin ? txWord[bitIdx] : 1'b0;
    din    = master ? sdIn : sdPipe[SYNC_STAGES-1];
    rxNext = firstBit ? {31'b0, din} : {rxSh[30:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdL <= '0; holdR <= '0; workL <= '0; workR <= '0;
      sdOut <= 1'b0; sdPipe <= '0; rxSh <= '0; leftHold <= '0;
      leftSeen <= 1'b0; rxLeft <= '0; rxRight <= '0; rxValid <= 1'b0;
    end else begin
      sdPipe  <= {sdPipe[SYNC_STAGES-2:0], sdIn};
      rxValid <= 1'b0;
      if (txValid) begin
        holdL <= txLeft;
        holdR <= txRight;
      end
      if (strb.fall) begin
        sdOut <= txBit;
        if (strb.pos == 6'd0) begin
          workL <= holdL;
          workR <= holdR;
        end
      end
      if (strb.rise && inWin) begin
        rxSh <= rxNext;
        if (lastBit) begin
          if (!ch) begin
            leftHold <= rxNext;
            leftSeen <= 1'b1;
          end else if (leftSeen) begin
            rxLeft   <= leftHold;
            rxRight  <= rxNext;
            rxValid  <= 1'b1;
            leftSeen <= 1'b0;
          end
        end
      end
    end
  end

  // R1: data line driven low through reset
  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> (sdOut == 1'b0));
  // R4: data line only moves with a falling bit clock edge
  assert_sdout_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.fall |=> $stable(sdOut));
  // R9: received-pair strobe is one cycle wide and follows a rising edge
  assert_rxvalid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);
  assert_rxvalid_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> $past(strb.rise));

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int DIV_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wordSel,
  input  logic [31:0] txLeft,
  input  logic [31:0] txRight,
  input  logic        txValid,
  output logic [31:0] rxLeft,
  output logic [31:0] rxRight,
  output logic        rxValid,
  input  logic        bitClkIn,
  input  logic        frameClkIn,
  input  logic        sdIn,
  output logic        bitClkOut,
  output logic        frameClkOut,
  output logic        sdOut
);

  aspStrobe_t strb;

  asp_ctrl #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .master(master),
    .bitClkIn(bitClkIn), .frameClkIn(frameClkIn),
    .bitClkOut(bitClkOut), .frameClkOut(frameClkOut), .strb(strb)
  );

  asp_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt), .wordSel(wordSel),
    .strb(strb), .txLeft(txLeft), .txRight(txRight), .txValid(txValid),
    .sdIn(sdIn), .sdOut(sdOut), .rxLeft(rxLeft), .rxRight(rxRight),
    .rxValid(rxValid)
  );

endmodule

// File: tb/audio_serial_port_test.sv
`timescale 1ns/1ps
module audio_serial_port_test;

  localparam int HALF_DIV = 2;
  localparam int SLV_H    = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, master = 1'b1, txValid = 1'b0;
  logic [1:0]  fmt = 2'd0, wordSel = 2'd2;
  logic [31:0] txLeft = '0, txRight = '0;
  logic        bitClkIn = 1'b0, frameClkIn = 1'b0, sdIn = 1'b0;
  logic [31:0] rxLeft, rxRight;
  logic        rxValid, bitClkOut, frameClkOut, sdOut;

  audio_serial_port #(.DIV_HALF(HALF_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt), .wordSel(wordSel),
    .txLeft(txLeft), .txRight(txRight), .txValid(txValid),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid),
    .bitClkIn(bitClkIn), .frameClkIn(frameClkIn), .sdIn(sdIn),
    .bitClkOut(bitClkOut), .frameClkOut(frameClkOut), .sdOut(sdOut)
  );

  int nRun = 0, nFail = 0;

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lenOf(logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 20 : (s == 2'd2) ? 24 : 32;
  endfunction

  function automatic logic [31:0] maskW(logic [31:0] w, logic [1:0] s);
    int n = lenOf(s);
    return (n == 32) ? w : (w & ((32'd1 << n) - 32'd1));
  endfunction

  // expected half-frame contents, slot p sits at bit 31-p
  function automatic logic [31:0] layout(logic [31:0] w, logic [1:0] f, logic [1:0] s);
    logic [31:0] m = maskW(w, s);
    int n = lenOf(s);
    if (f == 2'd1) return m;
    if (f == 2'd2) return (m << (32 - n)) >> 1;
    return m << (32 - n);
  endfunction

  // ---------------- slave clock generator ----------------
  logic slaveRun = 1'b0;
  always begin
    if (slaveRun) begin
      for (int s = 0; s < 64; s++) begin
        bitClkIn = 1'b0;
        repeat (SLV_H) @(negedge clk);
        bitClkIn = 1'b1;
        repeat (SLV_H - 2) @(negedge clk);
        frameClkIn = (((s + 1) % 64) >= 32);
        repeat (2) @(negedge clk);
      end
    end else @(negedge clk);
  end

  // ---------------- serial link monitor / far-end model ----------------
  logic [31:0] drvL = '0, drvR = '0, capL = '0, capR = '0, lastCapL = '0, lastCapR = '0;
  logic [31:0] gotL = '0, gotR = '0;
  logic prevB = 1'b0, prevF = 1'b0, lastLvl = 1'b0;
  int monPos = 0, frameCnt = 0, rises = 0, risesPerFrame = 0;
  int run = 0, lastHigh = 0, lastLow = 0, rxCnt = 0, rxRun = 0, rxMaxRun = 0;

  always @(posedge clk) begin
    #2;
    if (bitClkOut == prevB) run++;
    else begin
      if (prevB) lastHigh = run; else lastLow = run;
      run = 1;
    end
    if (prevB && !bitClkOut) begin
      if (frameClkOut != lastLvl) monPos = 0; else monPos = monPos + 1;
      lastLvl = frameClkOut;
      sdIn = frameClkOut ? drvR[31 - (monPos & 31)] : drvL[31 - (monPos & 31)];
    end
    if (!prevB && bitClkOut) begin
      rises++;
      if (frameClkOut) capR[31 - (monPos & 31)] = sdOut;
      else             capL[31 - (monPos & 31)] = sdOut;
      if (frameClkOut && monPos == 31) begin
        lastCapL = capL; lastCapR = capR; frameCnt++;
      end
    end
    if (!prevF && frameClkOut) begin
      risesPerFrame = rises; rises = 0;
    end
    if (rxValid) begin
      rxCnt++; gotL = rxLeft; gotR = rxRight; rxRun++;
      if (rxRun > rxMaxRun) rxMaxRun = rxRun;
    end else rxRun = 0;
    prevB = bitClkOut;
    prevF = frameClkOut;
  end

  task automatic waitFrames(int n);
    int target = frameCnt + n;
    while (frameCnt < target) @(negedge clk);
  endtask

  task automatic writeTx(logic [31:0] l, logic [31:0] r);
    @(negedge clk);
    txLeft = l; txRight = r; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    repeat (5) @(negedge clk);
    checkEq("R1 sdOut in reset", {31'b0, sdOut}, 32'd0);
    checkEq("R1 bitClkOut in reset", {31'b0, bitClkOut}, 32'd0);
    checkEq("R1 frameClkOut in reset", {31'b0, frameClkOut}, 32'd0);
    checkEq("R1 rxValid in reset", {31'b0, rxValid}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic testMasterClock();
    waitFrames(3);
    checkEq("R2 rises per frame", risesPerFrame, 64);
    checkEq("R2 high phase", lastHigh, HALF_DIV);
    checkEq("R2 low phase", lastLow, HALF_DIV);
  endtask

  task automatic testFormat(string tag, logic [1:0] f, logic [1:0] s,
                            logic [31:0] tl, logic [31:0] tr,
                            logic [31:0] rl, logic [31:0] rr);
    @(negedge clk);
    fmt = f; wordSel = s;
    drvL = layout(rl, f, s); drvR = layout(rr, f, s);
    writeTx(tl, tr);
    waitFrames(3);
    checkEq({tag, " tx left (R3 left=low)"}, lastCapL, layout(tl, f, s));
    checkEq({tag, " tx right"}, lastCapR, layout(tr, f, s));
    checkEq({tag, " rx left R9"}, gotL, maskW(rl, s));
    checkEq({tag, " rx right R9"}, gotR, maskW(rr, s));
  endtask

  task automatic testRxPulse();
    int c0;
    waitFrames(1);
    c0 = rxCnt;
    waitFrames(4);
    checkEq("R9 pulses per frame", rxCnt - c0, 4);
    checkEq("R9 pulse width", rxMaxRun, 1);
  endtask

  task automatic testLoadTiming();
    logic [31:0] aL = 32'h00A1B2C3, aR = 32'h00C3B2A1;
    logic [31:0] bL = 32'h00F00F5A, bR = 32'h00811881;
    @(negedge clk);
    fmt = 2'd0; wordSel = 2'd2;
    writeTx(aL, aR);
    waitFrames(3);
    do @(negedge clk); while (!(frameClkOut == 1'b0 && monPos >= 8 && monPos <= 20));
    writeTx(bL, bR);
    waitFrames(1);
    checkEq("R10 frame in progress left", lastCapL, layout(aL, 2'd0, 2'd2));
    checkEq("R10 frame in progress right", lastCapR, layout(aR, 2'd0, 2'd2));
    waitFrames(1);
    checkEq("R10 next frame left", lastCapL, layout(bL, 2'd0, 2'd2));
    checkEq("R10 next frame right", lastCapR, layout(bR, 2'd0, 2'd2));
  endtask

  task automatic testSlave();
    int mism = 0;
    logic [31:0] tl = 32'h00D4C3B2, tr = 32'h002B3C4D;
    logic [31:0] rl = 32'h0055AA33, rr = 32'h00CC3355;
    @(negedge clk);
    master = 1'b0; fmt = 2'd2; wordSel = 2'd2;
    drvL = layout(rl, 2'd2, 2'd2); drvR = layout(rr, 2'd2, 2'd2);
    slaveRun = 1'b1;
    writeTx(tl, tr);
    waitFrames(3);
    repeat (300) begin
      @(negedge clk);
      if (bitClkOut !== bitClkIn || frameClkOut !== frameClkIn) mism++;
    end
    checkEq("R11 clocks follow inputs", mism, 0);
    waitFrames(1);
    checkEq("R12 slave tx left", lastCapL, layout(tl, 2'd2, 2'd2));
    checkEq("R12 slave tx right", lastCapR, layout(tr, 2'd2, 2'd2));
    checkEq("R12 slave rx left", gotL, rl);
    checkEq("R12 slave rx right", gotR, rr);
    slaveRun = 1'b0;
  endtask

  initial begin
    testReset();
    testMasterClock();
    testFormat("R5 msb24", 2'd0, 2'd2, 32'h00ABCDEF, 32'h00123456, 32'h00FEDCBA, 32'h00654321);
    testFormat("R5 msb32", 2'd0, 2'd3, 32'h89ABCDEF, 32'h13579BDF, 32'hF0E1D2C3, 32'h2468ACE0);
    testFormat("R5 code3", 2'd3, 2'd1, 32'h000FACE5, 32'h000BEEF1, 32'h00012345, 32'h000ABCDE);
    testFormat("R6 lsb16", 2'd1, 2'd0, 32'h0000C0DE, 32'h00008001, 32'h0000BEEF, 32'h00001234);
    testFormat("R6 lsb20", 2'd1, 2'd1, 32'h000F1234, 32'h00080F0F, 32'h000ACE01, 32'h00077777);
    testFormat("R6 lsb24", 2'd1, 2'd2, 32'h00800001, 32'h007FFFFE, 32'h00A5A5A5, 32'h005A5A5A);
    testFormat("R7 i2s24", 2'd2, 2'd2, 32'h00C00003, 32'h00ABCDEF, 32'h00813579, 32'h00ECA864);
    testFormat("R7 i2s16", 2'd2, 2'd0, 32'h0000F00D, 32'h00008421, 32'h00001248, 32'h0000CAFE);
    testFormat("R8 unused zero", 2'd1, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    testRxPulse();
    testLoadTiming();
    testSlave();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule